// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a one-bit serial stream and raises a flag when the four most recent accepted bits spell either `0101` or `0110`. In both patterns the leftmost bit is the oldest. One bit is taken on each rising clock edge where the sample enable is high. Edges where the enable is low leave the detector untouched. That lets a slower upstream source share the fast clock without a gated clock.

The detector is a minimised Moore machine with seven states, held in one-hot form. Five states track how much of a shared prefix has been seen. Two accept states, one per pattern, drive the output. Matches may overlap: the tail of one match can start the next. The output comes straight from state flops, so it changes one clock after the completing bit is taken.

The reset input is asynchronous and active low. Its release is retimed inside the block through a short synchronizer, so the machine leaves reset on a clock edge.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst_n` is low, and until the first enabled sample after its release, `z_out` is 0 and the machine is in the idle state with no bits matched.
- R2: `z_out` is 1 in the cycle after an enabled edge when the last four enabled samples, oldest first, are `0101`.
- R3: `z_out` is 1 in the cycle after an enabled edge when the last four enabled samples, oldest first, are `0110`.
- R4: After any enabled edge where the last four enabled samples match neither pattern, or fewer than four samples have been taken since reset, `z_out` is 0.
- R5: Matches overlap. The stream `010110` gives a pulse after its fourth bit (`0101`) and another after its sixth bit (`0110`).
- R6: A match pulse lasts exactly one enabled cycle, because no two consecutive enabled samples can both complete a match.
- R7: On an edge where `sample_en` is 0, `x_in` is ignored: the state and `z_out` hold their values.
- R8: After reset the state vector is one-hot, and `z_out` never takes an unknown value.
- R9: Bits taken before a reset never contribute to a match after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release retimed internally |
| sample_en | input | 1 | When 1, `x_in` is taken on this edge |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Match flag, taken directly from the accept-state flops |

## Verification
The bench drives every ten-bit stream from reset and checks `z_out` after each bit against a four-bit history model. This sweep covers every overlap and every fall-back from a partial match. A machine with a wrong fall-back edge would miss `0101` hidden behind `010`, or would report matches that were never completed. A second sweep mixes in idle edges with `sample_en` low. A machine that shifted on those edges would take stale bits and would misplace its pulses. Directed runs reset in the middle of a partial pattern, and check that the first bits after reset cannot finish a match begun before it. They also check that the overlapping stream `010110` gives two separate one-cycle pulses.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  // One-hot bit positions of the detector states
  localparam int ST_IDLE  = 0;  // nothing of a prefix seen
  localparam int ST_P0    = 1;  // "0"
  localparam int ST_P01   = 2;  // "01"
  localparam int ST_P010  = 3;  // "010"
  localparam int ST_P011  = 4;  // "011"
  localparam int ST_HIT_A = 5;  // "0101" accepted
  localparam int ST_HIT_B = 6;  // "0110" accepted
  localparam int NUM_ST   = 7;
endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
#(
  parameter int N = NUM_ST
) (
  input  logic [N-1:0] cur,
  input  logic         x,
  output logic [N-1:0] nxt
);
  // Each state bit is the OR of its predecessors on the matching input value
  always_comb begin
    nxt           = '0;
    nxt[ST_IDLE]  = x  & (cur[ST_IDLE] | cur[ST_P011]);
    nxt[ST_P0]    = ~x & (cur[ST_IDLE] | cur[ST_P0] | cur[ST_P010] | cur[ST_HIT_B]);
    nxt[ST_P01]   = x  & (cur[ST_P0]   | cur[ST_HIT_B]);
    nxt[ST_P010]  = ~x & (cur[ST_P01]  | cur[ST_HIT_A]);
    nxt[ST_P011]  = x  & (cur[ST_P01]  | cur[ST_HIT_A]);
    nxt[ST_HIT_A] = x  & cur[ST_P010];
    nxt[ST_HIT_B] = ~x & cur[ST_P011];
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg #(
  parameter int N       = 7,
  parameter int RST_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  localparam logic [N-1:0] RST_VEC = (N)'(1) << RST_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VEC;
    else if (en) q <= d;
  end

  // R8: exactly one state flop set once out of reset
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot(q));
  // R7: a disabled edge leaves the state untouched
  p_hold_idle_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
  import seqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic x_in,
  output logic z_out
);
  logic              rst_sync_n;
  logic [NUM_ST-1:0] st_q;
  logic [NUM_ST-1:0] st_d;

  seqdet_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seqdet_next #(.N(NUM_ST)) u_next (
    .cur (st_q),
    .x   (x_in),
    .nxt (st_d)
  );

  seqdet_state_reg #(.N(NUM_ST), .RST_IDX(ST_IDLE)) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (sample_en),
    .d     (st_d),
    .q     (st_q)
  );

  // Moore output: accept states only
  assign z_out = st_q[ST_HIT_A] | st_q[ST_HIT_B];

  // R2: the 0101 accept state is entered only from "010" on an enabled 1
  p_enter_hit_a_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(st_q[ST_HIT_A]) |-> $past(st_q[ST_P010] && sample_en && x_in));
  // R3: the 0110 accept state is entered only from "011" on an enabled 0
  p_enter_hit_b_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(st_q[ST_HIT_B]) |-> $past(st_q[ST_P011] && sample_en && !x_in));
  // R6: no two consecutive enabled samples both complete a match
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_en && z_out) |=> !z_out);
  // R1: the output is low while the internal reset holds
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_sync_n |-> !z_out);
endmodule

// File: tb/test_seqdet_dual.sv
`timescale 1ns/1ps
module test_seqdet_dual;
  logic clk = 1'b0;
  logic rst_n;
  logic sample_en;
  logic x_in;
  logic z_out;

  int checks = 0;
  int errors = 0;
  logic [3:0] hist;
  int         taken;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  seqdet_dual i_seqdet_dual (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .x_in      (x_in),
    .z_out     (z_out)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if ($isunknown(z_out)) begin
      errors++;
      $display("FAIL R8 (%s): z_out=%b expected %0b", tag, z_out, exp);
    end else if (z_out !== exp) begin
      errors++;
      $display("FAIL %s: z_out=%0b expected %0b", tag, z_out, exp);
    end
  endtask

  // One edge; called at a falling edge, returns at the next falling edge
  task automatic step(input logic x, input logic en, input string tag_override = "");
    logic  exp;
    string tag;
    x_in = x;
    sample_en = en;
    @(posedge clk);
    if (en) begin
      hist = {hist[2:0], x};
      taken++;
    end
    exp = (taken >= 4) && (hist == 4'b0101 || hist == 4'b0110);
    @(negedge clk);
    if (tag_override != "")      tag = tag_override;
    else if (!en)                tag = "R7";
    else if (exp && hist[1])     tag = "R3";
    else if (exp)                tag = "R2";
    else                         tag = "R4";
    check(tag, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_en = 1'b0;
    x_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    hist = 4'b0000;
    taken = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
  endtask

  initial begin
    rst_n = 1'b0;
    sample_en = 1'b0;
    x_in = 1'b0;
    hist = '0;
    taken = 0;

    // Exhaustive sweep: every 10-bit stream from reset
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      for (int b = 9; b >= 0; b--) step(p[b], 1'b1);
    end

    // Sweep with idle edges: 8 data bits, enable mask from a second index
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int b = 7; b >= 0; b--) begin
        if (((p * 37 + b) % 3) == 0) step(~p[b], 1'b0);
        step(p[b], 1'b1);
        if (((p + b) % 5) == 0) begin
          step(p[b], 1'b0);
          step(~p[b], 1'b0);
        end
      end
    end

    // R5 and R6: overlapping stream 010110
    do_reset();
    step(0, 1, "R5"); step(1, 1, "R5"); step(0, 1, "R5");
    step(1, 1, "R5");            // 0101 complete -> pulse
    step(1, 1, "R6");            // pulse gone after one cycle
    step(0, 1, "R5");            // 0110 complete -> second pulse
    step(0, 1, "R6");

    // R9: partial 010 then reset; a following 1 must not match
    do_reset();
    step(0, 1); step(1, 1); step(0, 1);
    do_reset();
    step(1, 1, "R9");
    step(1, 1, "R9");
    step(0, 1, "R9");

    // R9: reset asserted mid-stream while the 011 prefix is held
    do_reset();
    step(0, 1); step(1, 1); step(1, 1);
    do_reset();
    step(0, 1, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule